// File: doc/BRIEF.md
# Transmit Completion Status Reporter

This block turns per-buffer transmit completion events into done-queue records. Each event carries a channel number, a descriptor index, the buffer's place in its packet and a set of error flags. The block keeps two bits of state per channel: an enable bit and a reporting-granularity bit. From these bits and the event it picks a 3-bit completion code and decides whether a record is written at all.

In packet granularity a record appears only when a packet ends. In buffer granularity every buffer produces a record whose code tells where the buffer sat in the packet. Any error disables the channel. After that, every event on the channel is reported as "not enabled" until software writes the enable bit again, or until a descriptor arrives with its revive flag set.

Records leave through a single output register with a valid/ready handshake. While a record waits to be taken, new events are held off.

Top module: `tx_done_reporter`

## Requirements
- R1: After reset every channel is disabled and no record is pending (`dq_valid`=0, `ev_ready`=1). An event on a channel that is disabled, and whose revive flag is clear, yields a record with code 100.
- R2: On an enabled channel in packet granularity (mode bit 0), a clean event with position last (11) or single (00) yields code 000. A clean event with position first (01) or middle (10) yields no record.
- R3: On an enabled channel in buffer granularity (mode bit 1), clean events yield these codes: first (01) gives 001, middle (10) gives 010, last (11) gives 011 and single (00) gives 011.
- R4: On an enabled channel, a channel mismatch or a zero byte count gives 101, a bus abort gives 110 and a FIFO underflow gives 111. Each record carries the event's descriptor index and channel.
- R5: When several conditions occur together, the code with the lowest value wins, in this order: 100, then 101, then 110, then 111.
- R6: Any error clears the channel's enable bit. Every later event on that channel then gives 100. Other channels are not affected.
- R7: A configuration write sets one channel's enable bit and mode bit, starting from the next event. If an event on the same channel is accepted in the same cycle, the event's effect on the enable bit wins.
- R8: An event with its revive flag set enables its channel and is processed like an event on an enabled channel. If that event also carries an error, the channel is disabled again.
- R9: A record stays valid, with a stable code, index and channel, until `dq_ready` is seen. `ev_ready` is low exactly while a record is pending and not being taken. At most one record is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | CH_W | Channel being configured |
| cfg_en | input | 1 | Enable bit value to write |
| cfg_mode | input | 1 | Mode value to write: 0 = packet, 1 = buffer |
| ev_valid | input | 1 | Completion event present |
| ev_ready | output | 1 | Event accepted this cycle when high |
| ev_chan | input | CH_W | Event channel |
| ev_pos | input | 2 | 00 single, 01 first, 10 middle, 11 last |
| ev_idx | input | IDX_W | Descriptor index |
| ev_revive | input | 1 | Descriptor carries the channel revive flag |
| ev_abort | input | 1 | Bus abort |
| ev_underflow | input | 1 | Transmit FIFO underflow |
| ev_mismatch | input | 1 | Channel number does not match the queue entry |
| ev_zero_len | input | 1 | Byte count of zero |
| dq_valid | output | 1 | Done record present |
| dq_ready | input | 1 | Done queue takes the record |
| dq_status | output | 3 | Completion code |
| dq_idx | output | IDX_W | Descriptor index of the record |
| dq_chan | output | CH_W | Channel of the record |

## Verification
The assertions check on every cycle that the handshake holds: a pending record stays stable and events are blocked while it waits. They also check that an event on a disabled channel gives 100 on the next cycle, that errors and the revive flag move the channel's enable bit, and that clean non-final buffers in packet granularity produce nothing. Some behaviours are shown only by the bench's scenarios, which keep a model of per-channel state: the exact position code in buffer granularity, the priority order among simultaneous errors, the isolation between channels, and recovery by a configuration write.

// File: rtl/txd_pkg.sv
package txd_pkg;
   typedef enum logic [1:0] {
      POS_SINGLE = 2'b00,
      POS_FIRST  = 2'b01,
      POS_MIDDLE = 2'b10,
      POS_LAST   = 2'b11
   } pos_e;

   typedef enum logic [2:0] {
      ST_PKT_OK    = 3'b000,
      ST_BUF_FIRST = 3'b001,
      ST_BUF_MID   = 3'b010,
      ST_BUF_LAST  = 3'b011,
      ST_NOT_EN    = 3'b100,
      ST_DESC_ERR  = 3'b101,
      ST_ABORT     = 3'b110,
      ST_UNDERFLOW = 3'b111
   } status_e;
endpackage

// File: rtl/txd_chan_state.sv
module txd_chan_state #(
   parameter int NUM_CH = 8,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_chan,
   input  logic              cfg_en,
   input  logic              cfg_mode,
   input  logic              upd_we,
   input  logic [CH_W-1:0]   upd_chan,
   input  logic              upd_en,
   output logic [NUM_CH-1:0] en_vec,
   output logic [NUM_CH-1:0] mode_vec
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit_cfg, hit_upd;
      assign hit_cfg = cfg_we && (cfg_chan == CH_W'(c));
      assign hit_upd = upd_we && (upd_chan == CH_W'(c));

      // event update has priority over a configuration write
      always_ff @(posedge clk) begin
         if (!rst_n)       en_vec[c] <= 1'b0;
         else if (hit_upd) en_vec[c] <= upd_en;
         else if (hit_cfg) en_vec[c] <= cfg_en;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)       mode_vec[c] <= 1'b0;
         else if (hit_cfg) mode_vec[c] <= cfg_mode;
      end
   end
endmodule

// File: rtl/txd_classify.sv
module txd_classify
   import txd_pkg::*;
(
   input  logic       ch_en,
   input  logic       ch_mode,
   input  logic       revive,
   input  logic [1:0] pos,
   input  logic       abort,
   input  logic       underflow,
   input  logic       mismatch,
   input  logic       zero_len,
   output logic       emit,
   output logic [2:0] status,
   output logic       new_en
);
   logic live;
   assign live = ch_en | revive;

   always_comb begin
      emit   = 1'b1;
      status = ST_NOT_EN;
      new_en = 1'b0;
      if (!live) begin
         status = ST_NOT_EN;
      end else if (mismatch || zero_len) begin
         status = ST_DESC_ERR;
      end else if (abort) begin
         status = ST_ABORT;
      end else if (underflow) begin
         status = ST_UNDERFLOW;
      end else begin
         new_en = 1'b1;
         if (ch_mode) begin
            case (pos_e'(pos))
               POS_FIRST:  status = ST_BUF_FIRST;
               POS_MIDDLE: status = ST_BUF_MID;
               default:    status = ST_BUF_LAST;
            endcase
         end else begin
            status = ST_PKT_OK;
            emit   = (pos_e'(pos) == POS_LAST) || (pos_e'(pos) == POS_SINGLE);
         end
      end
   end
endmodule

// File: rtl/txd_out_reg.sv
module txd_out_reg #(
   parameter int IDX_W = 16,
   parameter int CH_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [2:0]       in_status,
   input  logic [IDX_W-1:0] in_idx,
   input  logic [CH_W-1:0]  in_chan,
   input  logic             dq_ready,
   output logic             free,
   output logic             dq_valid,
   output logic [2:0]       dq_status,
   output logic [IDX_W-1:0] dq_idx,
   output logic [CH_W-1:0]  dq_chan
);
   assign free = !dq_valid || dq_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dq_valid <= 1'b0;
      end else if (load) begin
         dq_valid <= 1'b1;
      end else if (dq_ready) begin
         dq_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dq_status <= '0;
         dq_idx    <= '0;
         dq_chan   <= '0;
      end else if (load) begin
         dq_status <= in_status;
         dq_idx    <= in_idx;
         dq_chan   <= in_chan;
      end
   end
endmodule

// File: rtl/tx_done_reporter.sv
module tx_done_reporter #(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 16,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CH_W-1:0]  cfg_chan,
   input  logic             cfg_en,
   input  logic             cfg_mode,
   input  logic             ev_valid,
   output logic             ev_ready,
   input  logic [CH_W-1:0]  ev_chan,
   input  logic [1:0]       ev_pos,
   input  logic [IDX_W-1:0] ev_idx,
   input  logic             ev_revive,
   input  logic             ev_abort,
   input  logic             ev_underflow,
   input  logic             ev_mismatch,
   input  logic             ev_zero_len,
   output logic             dq_valid,
   input  logic             dq_ready,
   output logic [2:0]       dq_status,
   output logic [IDX_W-1:0] dq_idx,
   output logic [CH_W-1:0]  dq_chan
);
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must be at least 1");
   end

   logic [NUM_CH-1:0] en_vec, mode_vec;
   logic              acc, emit, new_en;
   logic [2:0]        cls_status;

   assign acc = ev_valid && ev_ready;

   txd_chan_state #(.NUM_CH(NUM_CH)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_chan (cfg_chan),
      .cfg_en   (cfg_en),
      .cfg_mode (cfg_mode),
      .upd_we   (acc),
      .upd_chan (ev_chan),
      .upd_en   (new_en),
      .en_vec   (en_vec),
      .mode_vec (mode_vec)
   );

   txd_classify u_cls (
      .ch_en     (en_vec[ev_chan]),
      .ch_mode   (mode_vec[ev_chan]),
      .revive    (ev_revive),
      .pos       (ev_pos),
      .abort     (ev_abort),
      .underflow (ev_underflow),
      .mismatch  (ev_mismatch),
      .zero_len  (ev_zero_len),
      .emit      (emit),
      .status    (cls_status),
      .new_en    (new_en)
   );

   txd_out_reg #(.IDX_W(IDX_W), .CH_W(CH_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (acc && emit),
      .in_status (cls_status),
      .in_idx    (ev_idx),
      .in_chan   (ev_chan),
      .dq_ready  (dq_ready),
      .free      (ev_ready),
      .dq_valid  (dq_valid),
      .dq_status (dq_status),
      .dq_idx    (dq_idx),
      .dq_chan   (dq_chan)
   );
endmodule

// File: rtl/txd_chk.sv
module txd_chk #(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 16,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid,
   input logic              ev_ready,
   input logic [CH_W-1:0]   ev_chan,
   input logic [1:0]        ev_pos,
   input logic              ev_revive,
   input logic              ev_abort,
   input logic              ev_underflow,
   input logic              ev_mismatch,
   input logic              ev_zero_len,
   input logic              dq_valid,
   input logic              dq_ready,
   input logic [2:0]        dq_status,
   input logic [IDX_W-1:0]  dq_idx,
   input logic [CH_W-1:0]   dq_chan,
   input logic [NUM_CH-1:0] en_vec,
   input logic [NUM_CH-1:0] mode_vec
);
   logic acc, any_err;
   assign acc     = ev_valid && ev_ready;
   assign any_err = ev_abort || ev_underflow || ev_mismatch || ev_zero_len;

   // R9
   dq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_valid && !dq_ready |=> dq_valid && $stable(dq_status) && $stable(dq_idx) && $stable(dq_chan));

   // R9
   ev_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_valid && !dq_ready |-> !ev_ready);

   // R1
   not_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !en_vec[ev_chan] && !ev_revive |=> dq_valid && dq_status == 3'b100);

   // R6
   err_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && any_err |=> !en_vec[$past(ev_chan)]);

   // R8
   revive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && ev_revive && !any_err |=> en_vec[$past(ev_chan)]);

   // R2
   pkt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (en_vec[ev_chan] || ev_revive) && !any_err && !mode_vec[ev_chan]
      && (ev_pos == 2'b01 || ev_pos == 2'b10) |=> !dq_valid);
endmodule

bind tx_done_reporter txd_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ev_valid     (ev_valid),
   .ev_ready     (ev_ready),
   .ev_chan      (ev_chan),
   .ev_pos       (ev_pos),
   .ev_revive    (ev_revive),
   .ev_abort     (ev_abort),
   .ev_underflow (ev_underflow),
   .ev_mismatch  (ev_mismatch),
   .ev_zero_len  (ev_zero_len),
   .dq_valid     (dq_valid),
   .dq_ready     (dq_ready),
   .dq_status    (dq_status),
   .dq_idx       (dq_idx),
   .dq_chan      (dq_chan),
   .en_vec       (en_vec),
   .mode_vec     (mode_vec)
);

// File: tb/tx_done_reporter_tb.sv
module tx_done_reporter_tb;
   localparam int NUM_CH = 8;
   localparam int IDX_W  = 16;
   localparam int CH_W   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_en = 0, cfg_mode = 0;
   logic [CH_W-1:0] cfg_chan = '0;
   logic ev_valid = 0, ev_revive = 0, ev_abort = 0, ev_underflow = 0, ev_mismatch = 0, ev_zero_len = 0;
   logic [CH_W-1:0] ev_chan = '0;
   logic [1:0] ev_pos = '0;
   logic [IDX_W-1:0] ev_idx = '0;
   logic dq_ready = 0;
   logic ev_ready, dq_valid;
   logic [2:0] dq_status;
   logic [IDX_W-1:0] dq_idx;
   logic [CH_W-1:0] dq_chan;

   int checks = 0, errors = 0;
   logic m_en [NUM_CH];
   logic m_mode [NUM_CH];

   always #4 clk = ~clk;

   tx_done_reporter #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_en(cfg_en),
      .cfg_mode(cfg_mode), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_chan(ev_chan),
      .ev_pos(ev_pos), .ev_idx(ev_idx), .ev_revive(ev_revive), .ev_abort(ev_abort),
      .ev_underflow(ev_underflow), .ev_mismatch(ev_mismatch), .ev_zero_len(ev_zero_len),
      .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_status(dq_status), .dq_idx(dq_idx),
      .dq_chan(dq_chan));

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // expected {emit, status, new enable}
   function automatic logic [4:0] expect_ev(input logic en, input logic mode, input logic rv,
                                            input logic [1:0] pos, input logic ab, input logic un,
                                            input logic mm, input logic zl);
      if (!(en || rv))  return {1'b1, 3'b100, 1'b0};
      if (mm || zl)     return {1'b1, 3'b101, 1'b0};
      if (ab)           return {1'b1, 3'b110, 1'b0};
      if (un)           return {1'b1, 3'b111, 1'b0};
      if (mode) begin
         case (pos)
            2'b01:   return {1'b1, 3'b001, 1'b1};
            2'b10:   return {1'b1, 3'b010, 1'b1};
            default: return {1'b1, 3'b011, 1'b1};
         endcase
      end
      return {(pos == 2'b11 || pos == 2'b00), 3'b000, 1'b1};
   endfunction

   task automatic cfg(input int ch, input logic en, input logic mode);
      @(negedge clk);
      cfg_we = 1; cfg_chan = CH_W'(ch); cfg_en = en; cfg_mode = mode;
      @(negedge clk);
      cfg_we = 0;
      m_en[ch] = en; m_mode[ch] = mode;
   endtask

   task automatic send(input string req, input int ch, input logic [1:0] pos, input int idx,
                       input logic rv, input logic ab, input logic un, input logic mm, input logic zl);
      logic [4:0] e;
      logic [2:0] held;
      e = expect_ev(m_en[ch], m_mode[ch], rv, pos, ab, un, mm, zl);
      @(negedge clk);
      check(ev_ready == 1'b1, "R9", int'(ev_ready), 1);
      ev_valid = 1; ev_chan = CH_W'(ch); ev_pos = pos; ev_idx = IDX_W'(idx);
      ev_revive = rv; ev_abort = ab; ev_underflow = un; ev_mismatch = mm; ev_zero_len = zl;
      @(negedge clk);
      ev_valid = 0; ev_revive = 0; ev_abort = 0; ev_underflow = 0; ev_mismatch = 0; ev_zero_len = 0;
      m_en[ch] = e[0];
      check(dq_valid == e[4], req, int'(dq_valid), int'(e[4]));
      if (e[4] && dq_valid) begin
         check(dq_status == e[3:1], req, int'(dq_status), int'(e[3:1]));
         check(dq_idx == IDX_W'(idx) && dq_chan == CH_W'(ch), "R4", int'(dq_idx), idx);
         held = dq_status;
         repeat ($urandom_range(0, 2)) begin
            check(ev_ready == 1'b0, "R9", int'(ev_ready), 0);
            @(negedge clk);
            check(dq_valid && dq_status == held, "R9", int'(dq_status), int'(held));
         end
         dq_ready = 1;
         @(negedge clk);
         dq_ready = 0;
         check(dq_valid == 1'b0, "R9", int'(dq_valid), 0);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd12345));
      for (int i = 0; i < NUM_CH; i++) begin m_en[i] = 0; m_mode[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(dq_valid == 1'b0, "R1", int'(dq_valid), 0);
      check(ev_ready == 1'b1, "R1", int'(ev_ready), 1);
      send("R1", 0, 2'b11, 10, 0, 0, 0, 0, 0);
      send("R1", 5, 2'b00, 11, 0, 0, 0, 0, 0);
      // R2 packet granularity
      cfg(1, 1, 0);
      send("R2", 1, 2'b01, 20, 0, 0, 0, 0, 0);
      send("R2", 1, 2'b10, 21, 0, 0, 0, 0, 0);
      send("R2", 1, 2'b11, 22, 0, 0, 0, 0, 0);
      send("R2", 1, 2'b00, 23, 0, 0, 0, 0, 0);
      // R3 buffer granularity
      cfg(2, 1, 1);
      send("R3", 2, 2'b01, 30, 0, 0, 0, 0, 0);
      send("R3", 2, 2'b10, 31, 0, 0, 0, 0, 0);
      send("R3", 2, 2'b11, 32, 0, 0, 0, 0, 0);
      send("R3", 2, 2'b00, 33, 0, 0, 0, 0, 0);
      // R4 and R6: abort disables channel 2 only
      send("R4", 2, 2'b10, 40, 0, 1, 0, 0, 0);
      send("R6", 2, 2'b11, 41, 0, 0, 0, 0, 0);
      send("R6", 1, 2'b11, 42, 0, 0, 0, 0, 0);
      // R7 software revives, then underflow
      cfg(2, 1, 1);
      send("R7", 2, 2'b01, 50, 0, 0, 0, 0, 0);
      send("R4", 2, 2'b10, 51, 0, 0, 1, 0, 0);
      // R8 revive flag on a descriptor
      send("R8", 2, 2'b11, 52, 1, 0, 0, 0, 0);
      send("R8", 2, 2'b01, 53, 0, 0, 0, 0, 0);
      send("R4", 2, 2'b01, 54, 0, 0, 0, 1, 0);
      send("R8", 2, 2'b00, 55, 1, 0, 0, 0, 1);
      send("R6", 2, 2'b00, 56, 0, 0, 0, 0, 0);
      // R5 priority
      send("R5", 3, 2'b11, 60, 0, 1, 1, 1, 1);
      cfg(3, 1, 0);
      send("R5", 3, 2'b11, 61, 0, 1, 1, 1, 0);
      cfg(3, 1, 0);
      send("R5", 3, 2'b11, 62, 0, 1, 1, 0, 0);
      cfg(3, 1, 0);
      send("R5", 3, 2'b11, 63, 0, 0, 1, 0, 0);
      // random mix
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 9) == 0)
            cfg($urandom_range(0, NUM_CH - 1), 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)));
         else
            send("R5", $urandom_range(0, NUM_CH - 1), 2'($urandom_range(0, 3)), $urandom_range(0, 65535),
                 1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 15) == 0),
                 1'($urandom_range(0, 15) == 0), 1'($urandom_range(0, 15) == 0),
                 1'($urandom_range(0, 15) == 0));
      end
      finish_run();
   end
endmodule